// File: doc/BRIEF.md
# Message Queue with Packed Status Word

This block is a small first-in first-out queue of 32-bit words that carries messages from one processor to another. A producer offers a word with a valid strobe; a consumer removes the oldest word with a pop strobe and sees that word on the pop data output in the same cycle. A separate peek output always shows the head slot without disturbing anything, so a consumer can inspect a message before it decides to take it.

The queue's state is packed into one 32-bit status word: a full flag, an empty flag and the current number of stored words. Every slot that is not holding a live message, whether it was never written, vacated by a pop or wiped by reset or clear, holds a fixed invalid marker. A read of an empty queue, through either the peek or the pop path, therefore returns a known value.

Storage is a register array rather than a memory, because every slot has to be returned to the marker at once. Arbitration between processors, address decoding and interrupt generation sit outside the block. The default depth is 8 words and the default marker is 0xFFFF_FFFF.

Top module: `mbx_fifo`

## Requirements
- R1: After reset the status word reads 0x4000_0000 (empty flag set, level 0), and both pop data and peek data read the invalid marker 0xFFFF_FFFF.
- R2: The status word has the full flag at bit 31, set exactly when the count equals the depth (8). It has the empty flag at bit 30, set exactly when the count is zero, and the count in bits 7:0. All other bits read zero. The status word follows the count with no further delay.
- R3: A push with valid high, no pop and a queue that is not full stores the word behind the last stored word and raises the count by one. Words leave in the order they were pushed.
- R4: A push while the queue is full is dropped. The stored words and the count are left unchanged, except for the effect of a pop in the same cycle.
- R5: A pop on a queue that is not empty presents the head word on pop data in the cycle of the strobe. The remaining words move one place toward the head and the count drops by one.
- R6: A slot vacated by a pop, or cleared by reset or clear, holds the invalid marker. Once the queue has been drained, peek data reads 0xFFFF_FFFF.
- R7: Peek data always shows the head slot and changes neither the count nor the contents.
- R8: A pop while the queue is empty returns 0xFFFF_FFFF on pop data and leaves the count and contents unchanged. A push in the same cycle still proceeds.
- R9: A push and a pop in the same cycle on a queue that is neither empty nor full removes the head and places the new word last. The count is unchanged.
- R10: A synchronous clear empties the queue and refills every slot with the marker at the next clock edge. It takes priority over a push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of the whole queue |
| push_vld | input | 1 | Push strobe |
| push_data | input | 32 | Word to push |
| pop | input | 1 | Pop strobe |
| pop_data | output | 32 | Head word during a pop, marker when empty |
| peek_data | output | 32 | Current head slot |
| status | output | 32 | Full flag, empty flag and level |

## Verification
A wrong count shows up in the status word in the cycle after the operation that caused it. It also skews which word appears at the head from then on. A slot that shifts wrongly or is not refilled with the marker stays hidden until it reaches the head. It then shows on peek data and pop data, up to depth pops later, so the stimulus drains the queue fully many times. The bench compares status, peek data and pop data against a reference queue on every cycle, so each divergence is caught in the first cycle it becomes visible.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned STAT_W         = 32;
  localparam int unsigned STAT_FULL_BIT  = 31;
  localparam int unsigned STAT_EMPTY_BIT = 30;
  localparam int unsigned LVL_W          = 8;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_vld,
  input  logic          pop,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] count
);
  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic          count_en;
  logic          is_full;
  logic          is_empty;

  always_comb begin
    is_full  = (count_q == CW'(DEPTH));
    is_empty = (count_q == '0);
    push_ok  = push_vld && !is_full && !clr;
    pop_ok   = pop && !is_empty && !clr;
    count_en = clr || (push_ok != pop_ok);
    if (clr)          count_d = '0;
    else if (push_ok) count_d = count_q + CW'(1);
    else              count_d = count_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/mbx_slots.sv
module mbx_slots #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32,
  parameter logic [DW-1:0] MARK = '1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [DW-1:0] push_data,
  input  logic [CW-1:0] count,
  output logic [DW-1:0] head
);
  logic [DW-1:0] slot_q [DEPTH];
  logic [CW-1:0] tail_idx;

  always_comb begin
    tail_idx = pop_ok ? (count - CW'(1)) : count;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] slot_d;
    logic          slot_en;
    logic [DW-1:0] upper;

    if (i == DEPTH - 1) begin : g_last
      assign upper = MARK;
    end else begin : g_mid
      assign upper = slot_q[i+1];
    end

    always_comb begin
      slot_en = 1'b0;
      slot_d  = slot_q[i];
      if (clr) begin
        slot_en = 1'b1;
        slot_d  = MARK;
      end else begin
        if (pop_ok && (CW'(i) < count)) begin
          slot_en = 1'b1;
          slot_d  = upper;
        end
        if (push_ok && (CW'(i) == tail_idx)) begin
          slot_en = 1'b1;
          slot_d  = push_data;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[i] <= MARK;
      else if (slot_en) slot_q[i] <= slot_d;
    end
  end

  assign head = slot_q[0];
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0]     count,
  output logic [STAT_W-1:0] status
);
  always_comb begin
    status                 = '0;
    status[LVL_W-1:0]      = LVL_W'(count);
    status[STAT_FULL_BIT]  = (count == CW'(DEPTH));
    status[STAT_EMPTY_BIT] = (count == '0);
  end
endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32,
  parameter logic [DW-1:0] MARK = '1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push_vld,
  input  logic [DW-1:0]     push_data,
  input  logic              pop,
  output logic [DW-1:0]     pop_data,
  output logic [DW-1:0]     peek_data,
  output logic [STAT_W-1:0] status
);
  logic          rst_sync_n;
  logic          push_ok;
  logic          pop_ok;
  logic [CW-1:0] count;
  logic [DW-1:0] head;

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mbx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .push_vld(push_vld),
    .pop(pop), .push_ok(push_ok), .pop_ok(pop_ok), .count(count)
  );

  mbx_slots #(.DEPTH(DEPTH), .DW(DW), .MARK(MARK)) u_slots (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .push_ok(push_ok),
    .pop_ok(pop_ok), .push_data(push_data), .count(count), .head(head)
  );

  mbx_status #(.DEPTH(DEPTH)) u_stat (
    .count(count), .status(status)
  );

  assign peek_data = head;
  assign pop_data  = (count == '0) ? MARK : head;
endmodule

// File: rtl/mbx_fifo_chk.sv
module mbx_fifo_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32,
  parameter logic [DW-1:0] MARK = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          push_vld,
  input logic          pop,
  input logic [DW-1:0] pop_data,
  input logic [DW-1:0] peek_data,
  input logic [31:0]   status
);
  logic full;
  logic empty;
  logic [7:0] lvl;
  assign full  = status[31];
  assign empty = status[30];
  assign lvl   = status[7:0];

  // R2
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (lvl == 8'(DEPTH)));
  // R2
  empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (lvl == 8'd0));
  // R3
  push_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && !pop && !clr && !full) |=> (lvl == $past(lvl) + 8'd1));
  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && !pop && !clr && full) |=> $stable(status));
  // R5
  pop_decr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push_vld && !clr && !empty) |=> (lvl == $past(lvl) - 8'd1));
  // R6
  empty_peek_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (peek_data == MARK));
  // R8
  empty_pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |-> (pop_data == MARK));
  // R8
  empty_pop_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push_vld && !clr && empty) |=> $stable(status));
  // R9
  both_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push_vld && !clr && !empty && !full) |=> $stable(lvl));
  // R10
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && (peek_data == MARK)));
endmodule

bind mbx_fifo mbx_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .MARK(MARK)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .clr(clr), .push_vld(push_vld), .pop(pop),
  .pop_data(pop_data), .peek_data(peek_data), .status(status)
);

// File: tb/tb_mbx_fifo.sv
`timescale 1ns/1ps
module tb_mbx_fifo;
  localparam int DEPTH = 8;
  localparam logic [31:0] MARK = 32'hFFFF_FFFF;

  logic clk;
  logic rst_n;
  logic clr;
  logic push_vld;
  logic [31:0] push_data;
  logic pop;
  logic [31:0] pop_data;
  logic [31:0] peek_data;
  logic [31:0] status;

  int checks;
  int failures;
  bit done;
  logic [31:0] q[$];
  logic [31:0] seed_word;

  mbx_fifo dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push_vld(push_vld),
    .push_data(push_data), .pop(pop), .pop_data(pop_data),
    .peek_data(peek_data), .status(status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = '0;
    s[7:0] = 8'(q.size());
    s[31]  = (q.size() == DEPTH);
    s[30]  = (q.size() == 0);
    return s;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle: inputs set at negedge, outputs checked before the edge,
  // model advanced at the edge.
  task automatic step(bit c, bit pu, logic [31:0] d, bit po);
    string tag;
    logic [31:0] head;
    bit pop_ok;
    bit push_ok;
    clr = c; push_vld = pu; push_data = d; pop = po;
    #1;
    head = (q.size() > 0) ? q[0] : MARK;
    if (c)                                  tag = "R10";
    else if (po && q.size() == 0)           tag = "R8";
    else if (pu && po && q.size() < DEPTH)  tag = "R9";
    else if (pu && q.size() == DEPTH)       tag = "R4";
    else if (po)                            tag = "R5";
    else if (pu)                            tag = "R3";
    else if (q.size() == 0)                 tag = "R6";
    else                                    tag = "R7";
    check("R2", "status", status, exp_status());
    check(tag, "peek_data", peek_data, head);
    if (po) check(tag, "pop_data", pop_data, head);
    @(posedge clk);
    pop_ok  = po && q.size() > 0 && !c;
    push_ok = pu && q.size() < DEPTH && !c;
    if (c) q.delete();
    else begin
      if (pop_ok)  void'(q.pop_front());
      if (push_ok) q.push_back(d);
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] next_word();
    seed_word = seed_word * 32'd1664525 + 32'd1013904223;
    return seed_word;
  endfunction

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    seed_word = 32'h1234_5678;
    clr = 0; push_vld = 0; push_data = '0; pop = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "status", status, 32'h4000_0000);
    check("R1", "peek_data", peek_data, MARK);
    check("R1", "pop_data", pop_data, MARK);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "status after release", status, 32'h4000_0000);
    // R8: pop on empty
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    // R3, R4: fill beyond capacity
    for (int i = 0; i < DEPTH + 3; i++) step(0, 1, 32'hA000_0000 + i, 0);
    // R4 with simultaneous pop while full
    step(0, 1, 32'hDEAD_0001, 1);
    // R9: push and pop together
    for (int i = 0; i < 5; i++) step(0, 1, 32'hB000_0000 + i, 1);
    // R7: idle peeks
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    // R5, R6: drain fully and past empty
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1);
    // R8 with push on empty
    step(0, 1, 32'hC000_0001, 1);
    step(0, 1, 32'hC000_0002, 0);
    // R10: clear with push and pop pending
    step(1, 1, 32'hC000_0003, 1);
    step(0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = next_word();
      step(r[7:0] == 8'd0, r[9:8] != 2'b00, next_word(), r[11:10] == 2'b11 || r[12]);
    end
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = next_word();
      step(1'b0, r[13], next_word(), r[14]);
    end
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 1);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule